// File: doc/BRIEF.md
# Compare-and-Branch Condition Unit

This block decides, for one compare-and-jump instruction at a time, whether the jump is taken, and it produces the address of the next fetch. The caller presents the 32-bit instruction word, the two register values already read for the instruction's source fields, the current instruction pointer and the jump-target register. A form-select input, derived from the opcode elsewhere, says whether the second operand is a register or the 16-bit immediate held in the instruction.

A 4-bit condition field chooses the comparison: always, equal, not equal, greater or greater-or-equal, each of the last two as unsigned or signed. A taken jump always goes to the jump-target register; there is no offset arithmetic. A fall-through advances the pointer by one, because addresses count 32-bit words. Condition codes outside the defined set never jump and instead flag an illegal condition. Register index 0 is treated as a hard zero, whatever value arrives on the operand input.

A valid strobe qualifies each evaluation, and all outputs are registered, so a result appears on the clock edge that samples the strobe.

Top module: `branch_cond_unit`

## Requirements
- R1: While reset is asserted and after it is released with no valid strobe, taken_o and illegal_o are 0 and next_ip_o is 0.
- R2: Field positions: condition code in instr_i[23:20], first source index in [19:16], second source index in [15:12], immediate in [15:0]. With imm_form_i = 0 the second operand is rs2_val_i and instr_i[11:0] has no effect; with imm_form_i = 1 the second operand is the immediate and rs2_val_i has no effect.
- R3: Code 0x0 is always taken; code 0x1 is taken when the operands differ; code 0x2 is taken when they are equal.
- R4: Code 0x3 is taken when the first operand is greater than the second as unsigned numbers, code 0x4 when greater or equal as unsigned; for these codes the immediate is zero-extended.
- R5: Code 0xC is taken when the first operand is greater than the second as signed numbers, code 0xD when greater or equal as signed; for these codes and for codes 0x1 and 0x2 the immediate is sign-extended.
- R6: When taken, next_ip_o equals jaddr_i; otherwise next_ip_o equals ip_i + 1 modulo 2^32.
- R7: A source index of 0 makes that operand read as zero regardless of rs1_val_i or rs2_val_i.
- R8: Codes 0x5 to 0xB, 0xE and 0xF are never taken and set illegal_o for the one result cycle of that evaluation; illegal_o is never 1 together with taken_o.
- R9: A cycle with valid_i = 0 gives taken_o = 0 and illegal_o = 0 on the next edge and leaves next_ip_o unchanged.
- R10: Results appear on the outputs at the rising edge that samples valid_i = 1, one clock after the inputs are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Evaluate the presented instruction this cycle |
| imm_form_i | input | 1 | 1 selects the immediate as second operand |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | 32 | Value read for the first source index |
| rs2_val_i | input | 32 | Value read for the second source index |
| ip_i | input | 32 | Current instruction pointer |
| jaddr_i | input | 32 | Jump-target register value |
| taken_o | output | 1 | Jump taken (registered) |
| illegal_o | output | 1 | Undefined condition code seen (registered) |
| next_ip_o | output | 32 | Next fetch address (registered) |

## Verification
A wrong operand choice or wrong extension of the immediate shows as a flipped taken_o, and with it a next_ip_o that jumps to jaddr_i instead of ip_i + 1 or the reverse, on the very edge after the strobe. A stuck or mis-held result register shows on the first idle cycle as a non-zero taken_o or illegal_o, or a next_ip_o that drifts. The operands chosen for the boundary cases (sign bit set against a small positive, equal values, an all-ones immediate, a zero index with a non-zero value on the bus) make each comparison disagree with its neighbouring code, so a swapped code or a signed/unsigned mix-up changes the port values at once.

// File: rtl/brc_pkg.sv
package brc_pkg;

    parameter int unsigned BRC_XLEN  = 32;
    parameter int unsigned BRC_IMM_W = 16;
    parameter int unsigned BRC_IDX_W = 4;
    parameter int unsigned BRC_CC_W  = 4;

    localparam logic [BRC_CC_W-1:0] CC_ALWAYS = 4'h0;
    localparam logic [BRC_CC_W-1:0] CC_NE     = 4'h1;
    localparam logic [BRC_CC_W-1:0] CC_EQ     = 4'h2;
    localparam logic [BRC_CC_W-1:0] CC_UGT    = 4'h3;
    localparam logic [BRC_CC_W-1:0] CC_UGE    = 4'h4;
    localparam logic [BRC_CC_W-1:0] CC_SGT    = 4'hC;
    localparam logic [BRC_CC_W-1:0] CC_SGE    = 4'hD;

    typedef struct packed {
        logic                taken;
        logic                illegal;
        logic [BRC_XLEN-1:0] next_ip;
    } brc_result_t;

    function automatic logic cc_is_unsigned(input logic [BRC_CC_W-1:0] cc);
        return (cc == CC_UGT) || (cc == CC_UGE);
    endfunction

endpackage

// File: rtl/brc_operand_sel.sv
module brc_operand_sel
    import brc_pkg::*;
#(
    parameter int unsigned XLEN  = BRC_XLEN,
    parameter int unsigned IMM_W = BRC_IMM_W,
    parameter int unsigned IDX_W = BRC_IDX_W
) (
    input  logic                imm_form_i,
    input  logic [BRC_CC_W-1:0] cc_i,
    input  logic [IDX_W-1:0]    src1_idx_i,
    input  logic [IDX_W-1:0]    src2_idx_i,
    input  logic [IMM_W-1:0]    imm_i,
    input  logic [XLEN-1:0]     src1_val_i,
    input  logic [XLEN-1:0]     src2_val_i,
    output logic [XLEN-1:0]     opa_o,
    output logic [XLEN-1:0]     opb_o
);
    localparam int unsigned PAD_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_ext;
    logic            fill_bit;

    // unsigned codes pad with zeros, every other code copies the sign bit
    assign fill_bit = cc_is_unsigned(cc_i) ? 1'b0 : imm_i[IMM_W-1];

    generate
        if (PAD_W > 0) begin : g_pad
            assign imm_ext = {{PAD_W{fill_bit}}, imm_i};
        end else begin : g_nopad
            assign imm_ext = imm_i[XLEN-1:0];
        end
    endgenerate

    always_comb begin
        opa_o = (src1_idx_i == '0) ? '0 : src1_val_i;
        if (imm_form_i) begin
            opb_o = imm_ext;
        end else begin
            opb_o = (src2_idx_i == '0) ? '0 : src2_val_i;
        end
    end

endmodule

// File: rtl/brc_compare.sv
module brc_compare
    import brc_pkg::*;
#(
    parameter int unsigned XLEN = BRC_XLEN
) (
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    output logic            eq_o,
    output logic            ugt_o,
    output logic            sgt_o
);
    logic sign_differs;

    assign eq_o         = (opa_i == opb_i);
    assign ugt_o        = (opa_i > opb_i);
    assign sign_differs = opa_i[XLEN-1] ^ opb_i[XLEN-1];
    // with differing signs the non-negative operand is the larger one
    assign sgt_o        = sign_differs ? ~opa_i[XLEN-1] : ugt_o;

endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_pkg::*;
(
    input  logic [BRC_CC_W-1:0] cc_i,
    input  logic                eq_i,
    input  logic                ugt_i,
    input  logic                sgt_i,
    output logic                taken_o,
    output logic                illegal_o
);
    always_comb begin
        taken_o   = 1'b0;
        illegal_o = 1'b0;
        case (cc_i)
            CC_ALWAYS: taken_o = 1'b1;
            CC_NE:     taken_o = ~eq_i;
            CC_EQ:     taken_o = eq_i;
            CC_UGT:    taken_o = ugt_i;
            CC_UGE:    taken_o = ugt_i | eq_i;
            CC_SGT:    taken_o = sgt_i;
            CC_SGE:    taken_o = sgt_i | eq_i;
            default:   illegal_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
    import brc_pkg::*;
#(
    parameter int unsigned XLEN  = BRC_XLEN,
    parameter int unsigned IMM_W = BRC_IMM_W,
    parameter int unsigned IDX_W = BRC_IDX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic            imm_form_i,
    input  logic [XLEN-1:0] instr_i,
    input  logic [XLEN-1:0] rs1_val_i,
    input  logic [XLEN-1:0] rs2_val_i,
    input  logic [XLEN-1:0] ip_i,
    input  logic [XLEN-1:0] jaddr_i,
    output logic            taken_o,
    output logic            illegal_o,
    output logic [XLEN-1:0] next_ip_o
);
    localparam int unsigned OPC_W   = 8;
    localparam int unsigned CC_LSB  = XLEN - OPC_W - BRC_CC_W;
    localparam int unsigned S1_LSB  = CC_LSB - IDX_W;
    localparam int unsigned S2_LSB  = S1_LSB - IDX_W;

    logic [OPC_W-1:0]    opcode_unused;
    logic [BRC_CC_W-1:0] cc;
    logic [IDX_W-1:0]    src1_idx;
    logic [IDX_W-1:0]    src2_idx;
    logic [IMM_W-1:0]    imm;
    logic [XLEN-1:0]     opa;
    logic [XLEN-1:0]     opb;
    logic                cmp_eq;
    logic                cmp_ugt;
    logic                cmp_sgt;
    logic                cond_taken;
    logic                cond_illegal;

    brc_result_t res_d;
    brc_result_t res_q;

    assign opcode_unused = instr_i[XLEN-1 -: OPC_W];
    assign cc            = instr_i[CC_LSB +: BRC_CC_W];
    assign src1_idx      = instr_i[S1_LSB +: IDX_W];
    assign src2_idx      = instr_i[S2_LSB +: IDX_W];
    assign imm           = instr_i[IMM_W-1:0];

    brc_operand_sel #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W),
        .IDX_W (IDX_W)
    ) i_opsel (
        .imm_form_i (imm_form_i),
        .cc_i       (cc),
        .src1_idx_i (src1_idx),
        .src2_idx_i (src2_idx),
        .imm_i      (imm),
        .src1_val_i (rs1_val_i),
        .src2_val_i (rs2_val_i),
        .opa_o      (opa),
        .opb_o      (opb)
    );

    brc_compare #(
        .XLEN (XLEN)
    ) i_cmp (
        .opa_i (opa),
        .opb_i (opb),
        .eq_o  (cmp_eq),
        .ugt_o (cmp_ugt),
        .sgt_o (cmp_sgt)
    );

    brc_cond_eval i_eval (
        .cc_i      (cc),
        .eq_i      (cmp_eq),
        .ugt_i     (cmp_ugt),
        .sgt_i     (cmp_sgt),
        .taken_o   (cond_taken),
        .illegal_o (cond_illegal)
    );

    always_comb begin
        res_d         = res_q;
        res_d.taken   = 1'b0;
        res_d.illegal = 1'b0;
        if (valid_i) begin
            res_d.taken   = cond_taken;
            res_d.illegal = cond_illegal;
            res_d.next_ip = cond_taken ? jaddr_i : ip_i + XLEN'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign taken_o   = res_q.taken;
    assign illegal_o = res_q.illegal;
    assign next_ip_o = res_q.next_ip;

    AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && taken_o) |-> (next_ip_o == $past(jaddr_i))); // R6

    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && !taken_o) |-> (next_ip_o == $past(ip_i) + XLEN'(1))); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(valid_i)) |-> (!taken_o && !illegal_o && $stable(next_ip_o))); // R9

    AST_ILLEGAL_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !taken_o); // R8

    AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && ($past(instr_i[CC_LSB +: BRC_CC_W]) == 4'h0)) |-> taken_o); // R3

    AST_ZERO_INDEX_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(valid_i) && !$past(imm_form_i)
         && ($past(instr_i[CC_LSB +: BRC_CC_W]) == 4'h2)
         && ($past(instr_i[S1_LSB +: IDX_W]) == '0)
         && ($past(instr_i[S2_LSB +: IDX_W]) == '0)) |-> taken_o); // R7

endmodule

// File: tb/test_branch_cond_unit.sv
module test_branch_cond_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        imm_form_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] rs1_val_i = '0;
    logic [31:0] rs2_val_i = '0;
    logic [31:0] ip_i = '0;
    logic [31:0] jaddr_i = '0;
    logic        taken_o;
    logic        illegal_o;
    logic [31:0] next_ip_o;

    int n_total = 0;
    int n_bad   = 0;
    logic [31:0] last_ip = '0;
    bit done = 1'b0;

    logic [33:0] q_exp[$];
    string       q_tag[$];
    logic [33:0] m_exp;
    string       m_tag;

    always #4 clk = ~clk;

    branch_cond_unit i_branch_cond_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (valid_i),
        .imm_form_i (imm_form_i),
        .instr_i    (instr_i),
        .rs1_val_i  (rs1_val_i),
        .rs2_val_i  (rs2_val_i),
        .ip_i       (ip_i),
        .jaddr_i    (jaddr_i),
        .taken_o    (taken_o),
        .illegal_o  (illegal_o),
        .next_ip_o  (next_ip_o)
    );

    function automatic logic [31:0] rform(input logic [3:0] cc, input logic [3:0] s1,
                                          input logic [3:0] s2, input logic [11:0] junk);
        return {8'h5A, cc, s1, s2, junk};
    endfunction

    function automatic logic [31:0] iform(input logic [3:0] cc, input logic [3:0] s1,
                                          input logic [15:0] im);
        return {8'h5B, cc, s1, im};
    endfunction

    task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: taken/illegal/next_ip actual=%b/%b/%h expected=%b/%b/%h",
                     tag, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
        end
    endtask

    // expected result from the requirement text (R2..R8)
    task automatic send(input logic form, input logic [31:0] ins, input logic [31:0] a_val,
                        input logic [31:0] b_val, input logic [31:0] ip, input logic [31:0] ja,
                        input string tag);
        logic [3:0]  cc;
        logic [31:0] a, b;
        logic        tk, ill;
        logic [31:0] nip;
        cc = ins[23:20];
        a  = (ins[19:16] == 4'd0) ? 32'd0 : a_val;
        if (form)
            b = (cc == 4'h3 || cc == 4'h4) ? {16'h0, ins[15:0]} : {{16{ins[15]}}, ins[15:0]};
        else
            b = (ins[15:12] == 4'd0) ? 32'd0 : b_val;
        ill = 1'b0;
        case (cc)
            4'h0: tk = 1'b1;
            4'h1: tk = (a != b);
            4'h2: tk = (a == b);
            4'h3: tk = (a > b);
            4'h4: tk = (a >= b);
            4'hC: tk = ($signed(a) > $signed(b));
            4'hD: tk = ($signed(a) >= $signed(b));
            default: begin tk = 1'b0; ill = 1'b1; end
        endcase
        nip = tk ? ja : ip + 32'd1;
        @(negedge clk); #1;
        valid_i = 1'b1; imm_form_i = form; instr_i = ins;
        rs1_val_i = a_val; rs2_val_i = b_val; ip_i = ip; jaddr_i = ja;
        q_exp.push_back({tk, ill, nip});
        q_tag.push_back(tag);
        last_ip = nip;
    endtask

    task automatic idle(input string tag);
        @(negedge clk); #1;
        valid_i = 1'b0; imm_form_i = 1'b0; instr_i = rform(4'h0, 4'h1, 4'h1, 12'hABC);
        rs1_val_i = 32'h1234_5678; ip_i = 32'h0BAD_0000; jaddr_i = 32'hDEAD_BEEF;
        q_exp.push_back({1'b0, 1'b0, last_ip});
        q_tag.push_back(tag);
    endtask

    // monitor: one result per cycle, sampled at the falling edge after the capture edge
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            m_exp = q_exp.pop_front();
            m_tag = q_tag.pop_front();
            check(m_tag, {taken_o, illegal_o, next_ip_o}, m_exp);
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", {taken_o, illegal_o, next_ip_o}, 34'd0);
        rst_n = 1'b1;
        idle("R1 after reset");

        // R3
        send(1'b0, rform(4'h0, 4'h1, 4'h2, 12'h000), 32'd5, 32'd9, 32'h100, 32'h4000, "R3 always");
        send(1'b0, rform(4'h1, 4'h1, 4'h2, 12'h000), 32'd5, 32'd9, 32'h101, 32'h4001, "R3 ne differ");
        send(1'b0, rform(4'h1, 4'h1, 4'h2, 12'h000), 32'd7, 32'd7, 32'h102, 32'h4002, "R3 ne equal");
        send(1'b0, rform(4'h2, 4'h1, 4'h2, 12'h000), 32'd7, 32'd7, 32'h103, 32'h4003, "R3 eq equal");
        send(1'b0, rform(4'h2, 4'h1, 4'h2, 12'h000), 32'd7, 32'd8, 32'h104, 32'h4004, "R3 eq differ");
        // R4
        send(1'b0, rform(4'h3, 4'h3, 4'h4, 12'h000), 32'h8000_0000, 32'd1, 32'h200, 32'h5000, "R4 ugt sign bit");
        send(1'b0, rform(4'h3, 4'h3, 4'h4, 12'h000), 32'd42, 32'd42, 32'h201, 32'h5001, "R4 ugt equal");
        send(1'b0, rform(4'h4, 4'h3, 4'h4, 12'h000), 32'd42, 32'd42, 32'h202, 32'h5002, "R4 uge equal");
        send(1'b1, iform(4'h3, 4'h3, 16'hFFFF), 32'h0001_0000, 32'd0, 32'h203, 32'h5003, "R4 imm zero-extend");
        send(1'b1, iform(4'h4, 4'h3, 16'h8000), 32'h0000_7FFF, 32'd0, 32'h204, 32'h5004, "R4 uge imm below");
        // R5
        send(1'b0, rform(4'hC, 4'h5, 4'h6, 12'h000), 32'h8000_0000, 32'd1, 32'h300, 32'h6000, "R5 sgt negative");
        send(1'b0, rform(4'hC, 4'h5, 4'h6, 12'h000), 32'd1, 32'hFFFF_FFFF, 32'h301, 32'h6001, "R5 sgt over -1");
        send(1'b0, rform(4'hD, 4'h5, 4'h6, 12'h000), 32'hFFFF_FFF0, 32'hFFFF_FFF0, 32'h302, 32'h6002, "R5 sge equal");
        send(1'b1, iform(4'hC, 4'h5, 16'hFFFF), 32'd0, 32'd0, 32'h303, 32'h6003, "R5 imm sign-extend");
        send(1'b1, iform(4'h2, 4'h5, 16'hFFFF), 32'hFFFF_FFFF, 32'd0, 32'h304, 32'h6004, "R5 eq imm sign-extend");
        // R2: ignored fields and ignored operand
        send(1'b0, rform(4'h2, 4'h1, 4'h2, 12'hFFF), 32'd77, 32'd77, 32'h400, 32'h7000, "R2 low bits ignored");
        send(1'b1, iform(4'h2, 4'h1, 16'h004D), 32'd77, 32'hFFFF_0000, 32'h401, 32'h7001, "R2 rs2 ignored in imm form");
        send(1'b0, rform(4'h1, 4'h1, 4'h2, 12'h04D), 32'd77, 32'd77, 32'h402, 32'h7002, "R2 reg form uses rs2");
        // R6
        send(1'b0, rform(4'h2, 4'h1, 4'h2, 12'h000), 32'd1, 32'd2, 32'hFFFF_FFFF, 32'h7003, "R6 ip wrap");
        // R7
        send(1'b1, iform(4'h2, 4'h0, 16'h0000), 32'hCAFE_0001, 32'd0, 32'h500, 32'h8000, "R7 rs1 index zero");
        send(1'b0, rform(4'h2, 4'h3, 4'h0, 12'h000), 32'd0, 32'hCAFE_0002, 32'h501, 32'h8001, "R7 rs2 index zero");
        send(1'b0, rform(4'hC, 4'h3, 4'h0, 12'h000), 32'hFFFF_FFFE, 32'd9, 32'h502, 32'h8002, "R7 sign test vs zero");
        // R8
        for (int c = 5; c <= 15; c++) begin
            if (c != 12 && c != 13)
                send(1'b0, rform(4'(c), 4'h1, 4'h2, 12'h000), 32'd3, 32'd3, 32'h600 + 32'(c), 32'h9000, "R8 illegal code");
        end
        idle("R8 illegal one cycle");
        // R9 / R10
        send(1'b0, rform(4'h0, 4'h1, 4'h2, 12'h000), 32'd0, 32'd0, 32'h700, 32'hA5A5_0000, "R10 taken next edge");
        idle("R9 idle after taken");
        idle("R9 idle holds");
        send(1'b0, rform(4'h1, 4'h1, 4'h2, 12'h000), 32'd4, 32'd4, 32'h7FF, 32'h1111, "R10 fall-through");
        idle("R9 idle holds fall-through");
        idle("R9 final idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule